// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt events from external edge pins, a small watched port and a group of timer overflow strobes. It records each event in a sticky pending flag and turns the flags into interrupt requests for a processor core. Every source owns a pending flag, an enable bit and a level bit. A master enable, a separate enable for the lower level and a mode bit decide which requests reach the core.

In two-level mode, sources whose level bit is set raise the high request, which carries vector 0x08. The other sources raise the low request, which carries vector 0x18. A high request may break into a running low handler, but a low request never breaks into a high handler. In single-level mode the level bits and the lower enable have no effect, and every source raises the high request.

The core takes a request with a one-cycle accept strobe. Accepting masks the level being entered. A one-cycle return strobe unmasks the level of the handler that is ending, newest first.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset the pending flags, both request outputs and the vector output are all zero, and the vector output stays zero whenever no request is presented.
- R2: A rising edge on external pin i sets pending bit i, and a strobe on timer input j sets pending bit N_EXT+1+j. Both happen at the clock edge that samples them, whatever the enable, level and master-enable settings are.
- R3: When the watched port value differs from the value it had one clock earlier, pending bit N_EXT is set, including differences between the last reset cycle and the first cycle after reset.
- R4: Pending bits are cleared only by a configuration write with select 2, which clears every bit that is 1 in the write data. A source event in the same cycle wins, and that bit stays set.
- R5: A request appears one clock after an enabled pending bit is visible, and only while the master enable (write select 3, data bit 0) is 1. Write select 0 loads the enable bits.
- R6: In two-level mode (select 3, data bit 2 = 1), sources with level bit 1 (loaded by select 1) raise irq_hi with vector 0x08. Sources with level bit 0 raise irq_lo with vector 0x18, and only while the lower enable (select 3, data bit 1) is also 1.
- R7: In single-level mode every enabled pending source raises irq_hi with vector 0x08, whatever its level bit or the lower enable is, and irq_lo stays 0.
- R8: Accepting a high request clears the master enable. The request is gone one clock later, and no request of either level appears until a return.
- R9: Accepting a low request clears the lower enable only. An enabled high-level source may then raise irq_hi inside the low handler.
- R10: A return strobe restores the enable of the newest unfinished level, high before low. Requests that were held back reappear one clock after the enable is restored.
- R11: When high and low sources are pending together, only irq_hi is raised; the two request outputs are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | N_EXT | External pins, rising-edge sensitive |
| port_in | input | PORT_W | Watched port, any change is an event |
| tmr_pulse | input | N_TMR | Timer overflow strobes, one cycle each |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 enables, 1 levels, 2 flag clear, 3 control |
| cfg_wdata | input | NF | Write data |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_hi | output | 1 | High-level request |
| irq_lo | output | 1 | Low-level request |
| irq_vec | output | VEC_W | Vector of the presented request, zero when idle |
| pend_flags | output | NF | Pending flags |

## Verification
The assertions assume the core follows the handshake. It accepts only while a request is shown, never accepts and returns in the same cycle, and does not rewrite the control register while a handler is active. The stimulus keeps to these rules: every accept comes after a request has been seen, every return pairs with an earlier accept, and control writes happen only when no handler is running. The bench's behavioural model keeps the active levels as a queue. It is compared with the outputs on every clock, and extra directed checks look at the preemption, masking and set-beats-clear cases.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_LEVEL   = 2'd1,
    SEL_FLAGCLR = 2'd2,
    SEL_CTRL    = 2'd3
  } cfg_sel_e;

  localparam int CTRL_GIE_HI = 0;
  localparam int CTRL_GIE_LO = 1;
  localparam int CTRL_MODE   = 2;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int N_EXT  = 3,
  parameter int PORT_W = 4,
  parameter int N_TMR  = 4,
  parameter int NF     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic [N_TMR-1:0]  tmr_pulse,
  input  logic              clr_we,
  input  logic [NF-1:0]     clr_mask,
  output logic [NF-1:0]     flags
);
  localparam int PC_BIT  = N_EXT;
  localparam int TMR_OFF = N_EXT + 1;

  logic [N_EXT-1:0]  ext_prev;
  logic [N_EXT-1:0]  ext_rise;
  logic [PORT_W-1:0] port_seen;
  logic              pc_hit;
  logic [NF-1:0]     set_vec;
  logic [NF-1:0]     clr_vec;

  // rising edge detectors, one per external pin
  for (genvar g = 0; g < N_EXT; g++) begin : g_edge
    assign ext_rise[g] = ext_pin[g] & ~ext_prev[g];
  end

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= '0;
    else     ext_prev <= ext_pin;
  end

  // port copy is refreshed on every edge, reset included, so the first
  // cycle out of reset compares against a valid value
  always_ff @(posedge clk) port_seen <= port_in;

  assign pc_hit  = (port_in != port_seen);
  assign set_vec = {tmr_pulse, pc_hit, ext_rise};
  assign clr_vec = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_vec) | set_vec;
  end

  // a pending bit only drops under a software clear of that bit
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (($past(flags) & ~flags & ~$past(clr_vec)) == '0));

  // a timer strobe always lands, even against a clear
  p_tmr_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|tmr_pulse) |=> ((flags[TMR_OFF +: N_TMR] & $past(tmr_pulse)) == $past(tmr_pulse)));

  p_port_change_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_in) |=> flags[PC_BIT]);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [NF-1:0] cfg_wdata,
  output logic [NF-1:0] enables,
  output logic [NF-1:0] levels,
  output logic          prio_mode,
  output logic          clr_we,
  output logic          ctrl_we
);
  cfg_sel_e sel;
  assign sel     = cfg_sel_e'(cfg_sel);
  assign clr_we  = cfg_we && (sel == SEL_FLAGCLR);
  assign ctrl_we = cfg_we && (sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      enables   <= '0;
      levels    <= '0;
      prio_mode <= 1'b0;
    end else if (cfg_we) begin
      case (sel)
        SEL_ENABLE: enables   <= cfg_wdata;
        SEL_LEVEL:  levels    <= cfg_wdata;
        SEL_CTRL:   prio_mode <= cfg_wdata[CTRL_MODE];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int          NF     = 8,
  parameter int          VEC_W  = 8,
  parameter int unsigned VEC_HI = 'h08,
  parameter int unsigned VEC_LO = 'h18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NF-1:0]    flags,
  input  logic [NF-1:0]    enables,
  input  logic [NF-1:0]    levels,
  input  logic             prio_mode,
  input  logic             ctrl_we,
  input  logic             ctrl_gie_hi,
  input  logic             ctrl_gie_lo,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_hi,
  output logic             irq_lo,
  output logic [VEC_W-1:0] irq_vec
);
  localparam logic [VEC_W-1:0] VH = VEC_W'(VEC_HI);
  localparam logic [VEC_W-1:0] VL = VEC_W'(VEC_LO);

  logic          gie_hi, gie_lo;
  logic          in_hi, in_lo;
  logic [NF-1:0] armed, hi_src, lo_src;
  logic          hi_pend, lo_pend;
  logic          take_hi, take_lo, taken;
  logic          ret_hi, ret_lo;

  assign armed   = flags & enables;
  assign hi_src  = prio_mode ? (armed & levels) : armed;
  assign lo_src  = prio_mode ? (armed & ~levels) : '0;
  assign hi_pend = gie_hi && (|hi_src);
  assign lo_pend = prio_mode && gie_hi && gie_lo && (|lo_src);

  assign take_hi = irq_ack && irq_hi;
  assign take_lo = irq_ack && irq_lo && !irq_hi;
  assign taken   = take_hi || take_lo;
  assign ret_hi  = irq_ret && in_hi;
  assign ret_lo  = irq_ret && !in_hi && in_lo;

  // masks and handler levels; handshake wins over a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      gie_hi <= 1'b0;
      gie_lo <= 1'b0;
      in_hi  <= 1'b0;
      in_lo  <= 1'b0;
    end else begin
      if (take_hi)      gie_hi <= 1'b0;
      else if (ret_hi)  gie_hi <= 1'b1;
      else if (ctrl_we) gie_hi <= ctrl_gie_hi;

      if (take_lo)      gie_lo <= 1'b0;
      else if (ret_lo)  gie_lo <= 1'b1;
      else if (ctrl_we) gie_lo <= ctrl_gie_lo;

      if (take_hi)     in_hi <= 1'b1;
      else if (ret_hi) in_hi <= 1'b0;

      if (take_lo)     in_lo <= 1'b1;
      else if (ret_lo) in_lo <= 1'b0;
    end
  end

  // request outputs are registered; an accept drops them at once
  always_ff @(posedge clk) begin
    if (rst || taken) begin
      irq_hi  <= 1'b0;
      irq_lo  <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_hi  <= hi_pend;
      irq_lo  <= lo_pend && !hi_pend;
      irq_vec <= hi_pend ? VH : (lo_pend ? VL : '0);
    end
  end

  p_req_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(irq_hi && irq_lo));

  p_ack_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_hi) |=> !irq_hi);

  p_no_lo_in_hi_r8: assert property (@(posedge clk) disable iff (rst)
    in_hi |-> !irq_lo);

  p_lo_gated_r6: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(gie_lo));

  p_vec_lo_r6: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> (irq_vec == VL));

  p_vec_hi_r6: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> (irq_vec == VH));

  p_single_level_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(prio_mode) |-> !irq_lo);

  p_ret_restores_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && in_hi && !irq_ack) |=> gie_hi);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int          N_EXT  = 3,
  parameter int          PORT_W = 4,
  parameter int          N_TMR  = 4,
  parameter int          VEC_W  = 8,
  parameter int unsigned VEC_HI = 'h08,
  parameter int unsigned VEC_LO = 'h18,
  localparam int         NF     = N_EXT + 1 + N_TMR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic [N_TMR-1:0]  tmr_pulse,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [NF-1:0]     cfg_wdata,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [NF-1:0]     pend_flags
);
  logic [NF-1:0] enables, levels;
  logic          prio_mode, clr_we, ctrl_we;

  irq_cfg_regs #(.NF(NF)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .enables   (enables),
    .levels    (levels),
    .prio_mode (prio_mode),
    .clr_we    (clr_we),
    .ctrl_we   (ctrl_we)
  );

  irq_src_capture #(
    .N_EXT (N_EXT),
    .PORT_W(PORT_W),
    .N_TMR (N_TMR),
    .NF    (NF)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .ext_pin   (ext_pin),
    .port_in   (port_in),
    .tmr_pulse (tmr_pulse),
    .clr_we    (clr_we),
    .clr_mask  (cfg_wdata),
    .flags     (pend_flags)
  );

  irq_arbiter #(
    .NF    (NF),
    .VEC_W (VEC_W),
    .VEC_HI(VEC_HI),
    .VEC_LO(VEC_LO)
  ) u_arb (
    .clk         (clk),
    .rst         (rst),
    .flags       (pend_flags),
    .enables     (enables),
    .levels      (levels),
    .prio_mode   (prio_mode),
    .ctrl_we     (ctrl_we),
    .ctrl_gie_hi (cfg_wdata[CTRL_GIE_HI]),
    .ctrl_gie_lo (cfg_wdata[CTRL_GIE_LO]),
    .irq_ack     (irq_ack),
    .irq_ret     (irq_ret),
    .irq_hi      (irq_hi),
    .irq_lo      (irq_lo),
    .irq_vec     (irq_vec)
  );
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int NE = 3, PW = 4, NT = 4, NF = 8, VW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] ext_pin = '0;
  logic [PW-1:0] port_in = '0;
  logic [NT-1:0] tmr_pulse = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [NF-1:0] cfg_wdata = '0;
  logic          irq_ack = 1'b0, irq_ret = 1'b0;
  logic          irq_hi, irq_lo;
  logic [VW-1:0] irq_vec;
  logic [NF-1:0] pend_flags;

  always #10 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .port_in(port_in),
    .tmr_pulse(tmr_pulse), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_hi(irq_hi), .irq_lo(irq_lo), .irq_vec(irq_vec),
    .pend_flags(pend_flags)
  );

  int    n_chk = 0, n_err = 0;
  string tag = "R1";
  bit    done = 1'b0;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference: handler levels kept as a queue
  logic [NF-1:0] m_fl, m_en, m_lv, m_vec;
  logic [NE-1:0] m_prev;
  logic [PW-1:0] m_port;
  bit            m_mode, m_gh, m_gl, m_hi, m_lo;
  int            lvl[$];

  always @(posedge clk) begin : model
    logic [NF-1:0] a, setv, clrv;
    bit hp, lp, took;
    if (rst) begin
      m_fl = '0; m_en = '0; m_lv = '0; m_vec = '0; m_prev = '0;
      m_mode = 0; m_gh = 0; m_gl = 0; m_hi = 0; m_lo = 0;
      lvl.delete();
    end else begin
      a    = m_fl & m_en;
      hp   = m_gh && (m_mode ? ((a & m_lv) != 0) : (a != 0));
      lp   = m_mode && m_gh && m_gl && ((a & ~m_lv) != 0);
      took = irq_ack && (m_hi || m_lo);
      setv = {tmr_pulse, (port_in != m_port), ext_pin & ~m_prev};
      clrv = (cfg_we && cfg_sel == 2'd2) ? cfg_wdata : '0;
      if (cfg_we) begin
        if (cfg_sel == 2'd0) m_en = cfg_wdata;
        if (cfg_sel == 2'd1) m_lv = cfg_wdata;
        if (cfg_sel == 2'd3) begin
          m_gh = cfg_wdata[0]; m_gl = cfg_wdata[1]; m_mode = cfg_wdata[2];
        end
      end
      if (took) begin
        if (m_hi) begin lvl.push_back(1); m_gh = 0; end
        else      begin lvl.push_back(0); m_gl = 0; end
      end else if (irq_ret && lvl.size() > 0) begin
        if (lvl[$] == 1) m_gh = 1; else m_gl = 1;
        void'(lvl.pop_back());
      end
      m_hi  = !took && hp;
      m_lo  = !took && lp && !hp;
      m_vec = m_hi ? 8'h08 : (m_lo ? 8'h18 : 8'h00);
      m_fl  = (m_fl & ~clrv) | setv;
      m_prev = ext_pin;
    end
    m_port = port_in;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, "model irq_hi", 32'(irq_hi), 32'(m_hi));
      chk(tag, "model irq_lo", 32'(irq_lo), 32'(m_lo));
      chk(tag, "model irq_vec", 32'(irq_vec), 32'(m_vec));
      chk(tag, "model pend_flags", 32'(pend_flags), 32'(m_fl));
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask
  task automatic wr(logic [1:0] s, logic [NF-1:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d; tick(1); cfg_we = 0; cfg_wdata = '0;
  endtask
  task automatic tpulse(int j);
    tmr_pulse[j] = 1'b1; tick(1); tmr_pulse = '0;
  endtask
  task automatic epulse(int j);
    ext_pin[j] = 1'b1; tick(1); ext_pin = '0;
  endtask
  task automatic ackp; irq_ack = 1; tick(1); irq_ack = 0; endtask
  task automatic retp; irq_ret = 1; tick(1); irq_ret = 0; endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 0;
    tick(2);
    // R1 reset state
    chk("R1", "flags", 32'(pend_flags), 0);
    chk("R1", "irq_hi", 32'(irq_hi), 0);
    chk("R1", "irq_lo", 32'(irq_lo), 0);
    chk("R1", "irq_vec", 32'(irq_vec), 0);

    // R2 pin edge held high counts once; timer strobe; no enables set
    tag = "R2";
    ext_pin[1] = 1; tick(3); ext_pin = '0;
    tpulse(2); tick(2);
    chk("R2", "flags", 32'(pend_flags), 32'h42);
    chk("R5", "irq_hi without enable", 32'(irq_hi), 0);

    // R3 port change
    tag = "R3";
    port_in = 4'h5; tick(3);
    chk("R3", "flags", 32'(pend_flags), 32'h4A);

    // R4 clear and set-beats-clear
    tag = "R4";
    wr(2'd2, 8'hFF); tick(2);
    chk("R4", "flags cleared", 32'(pend_flags), 0);
    tmr_pulse[0] = 1; cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = 8'h10;
    tick(1); tmr_pulse = '0; cfg_we = 0; cfg_wdata = '0;
    tick(2);
    chk("R4", "set wins", 32'(pend_flags), 32'h10);
    wr(2'd2, 8'hFF); tick(1);

    // R7 single level: level bits 0, lower enable 0, still high request
    tag = "R7";
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    tpulse(1); tick(3);
    chk("R7", "irq_hi", 32'(irq_hi), 1);
    chk("R7", "irq_lo", 32'(irq_lo), 0);
    chk("R7", "vector", 32'(irq_vec), 32'h08);

    // R8 accept masks everything
    tag = "R8";
    ackp(); tick(2);
    chk("R8", "irq_hi after accept", 32'(irq_hi), 0);
    tpulse(3); tick(3);
    chk("R8", "no request in handler", 32'(irq_hi | irq_lo), 0);

    // R10 return restores
    tag = "R10";
    retp(); tick(3);
    chk("R10", "irq_hi after return", 32'(irq_hi), 1);
    wr(2'd2, 8'hFF); tick(3);
    chk("R10", "irq_hi after clear", 32'(irq_hi), 0);

    // R5 gating by master enable and by enable bits
    tag = "R5";
    wr(2'd3, 8'h04); wr(2'd1, 8'hF0);
    tpulse(0); epulse(0); tick(3);
    chk("R5", "master off", 32'(irq_hi | irq_lo), 0);
    wr(2'd2, 8'hFF); wr(2'd0, 8'hFE); wr(2'd3, 8'h07);
    epulse(0); tick(3);
    chk("R5", "enable bit off", 32'(irq_hi | irq_lo), 0);

    // R6 low request and lower enable
    tag = "R6";
    wr(2'd0, 8'hFF); tick(3);
    chk("R6", "irq_lo", 32'(irq_lo), 1);
    chk("R6", "vector low", 32'(irq_vec), 32'h18);
    wr(2'd3, 8'h05); tick(3);
    chk("R6", "lower enable off", 32'(irq_lo), 0);
    wr(2'd3, 8'h07); tick(3);
    chk("R6", "lower enable on", 32'(irq_lo), 1);

    // R9 preemption of a low handler
    tag = "R9";
    ackp(); tick(2);
    chk("R9", "irq_lo after accept", 32'(irq_lo), 0);
    tpulse(0); tick(3);
    chk("R9", "preempt irq_hi", 32'(irq_hi), 1);
    chk("R9", "preempt vector", 32'(irq_vec), 32'h08);
    ackp(); tick(2);
    chk("R9", "irq_hi after accept", 32'(irq_hi), 0);
    wr(2'd2, 8'h10); tick(1);

    // R10 nested returns, newest first
    tag = "R10";
    retp(); tick(3);
    chk("R10", "low still masked", 32'(irq_hi | irq_lo), 0);
    retp(); tick(3);
    chk("R10", "low back", 32'(irq_lo), 1);
    wr(2'd2, 8'hFF); tick(3);
    chk("R10", "low cleared", 32'(irq_lo), 0);

    // R11 both pending
    tag = "R11";
    ext_pin[0] = 1; tmr_pulse[1] = 1; tick(1); ext_pin = '0; tmr_pulse = '0;
    tick(3);
    chk("R11", "irq_hi", 32'(irq_hi), 1);
    chk("R11", "irq_lo", 32'(irq_lo), 0);
    chk("R11", "vector", 32'(irq_vec), 32'h08);
    ackp(); tick(3);
    chk("R8", "low blocked in high handler", 32'(irq_lo), 0);
    retp(); tick(3);
    chk("R11", "high again", 32'(irq_hi), 1);
    wr(2'd2, 8'h20); tick(3);
    chk("R11", "low after high cleared", 32'(irq_lo), 1);
    wr(2'd2, 8'hFF); tick(3);

    done = 1;
    summary();
    $finish;
  end
endmodule